// File: doc/BRIEF.md
# Signed Register-Mapped Divider

This peripheral divides a 32-bit two's-complement dividend by a 16-bit two's-complement divisor. Software first stores the dividend. It then stores the divisor, and that store launches the calculation. An iterative restoring datapath produces one quotient bit per clock, and a final cycle applies the signs. A status word tells software when the result is ready and whether the last divisor it stored was zero.

The quotient is truncated toward zero and returned as 32 bits. The remainder carries the sign of the dividend. Its magnitude is always below that of the divisor, so it fits in 16 signed bits, and it is returned sign-extended to 32 bits. A zero divisor skips the iteration entirely and gives a fixed result in the same cycle. A second divisor store while a calculation is running abandons that calculation and starts again from the register contents at that moment.

Access is a single synchronous port. A write happens on a clock edge while the write enable is high. Reads are combinational from the byte address, and only word-aligned addresses decode.

Top module: `sdiv_unit`

## Requirements
- R1: Word index 0 (byte 0x00) holds the 32-bit dividend and index 1 (byte 0x04) holds the divisor. Both can be written and read back. Only the divisor's low 16 bits are kept, and bits [31:16] of the divisor read back as zero.
- R2: A write to byte 0x04 starts a division. The status word at byte 0x10 has a done flag in bit 0. That flag reads 0 for exactly DW+FIX_STAGE clock cycles after the write edge (33 with the defaults) and reads 1 otherwise.
- R3: After completion, byte 0x08 holds the quotient truncated toward zero, taken as the low 32 bits of the exact quotient. For example, -2^31 divided by -1 gives 0x80000000.
- R4: After completion, byte 0x0C holds the remainder. It has the sign of the dividend and a magnitude below that of the divisor. Bits [31:16] repeat bit 15.
- R5: Bit 1 of the status word is rewritten on every divisor write. It reads 1 when the written low 16 bits are zero and 0 otherwise.
- R6: A zero divisor leaves the done flag at 1 with no busy cycle. The quotient becomes 0xFFFFFFFF, and the remainder becomes the dividend's low 16 bits, sign-extended.
- R7: After reset, the status word reads 0x00000001 and every other register reads 0.
- R8: Writes to bytes 0x08, 0x0C and 0x10 are ignored, as are writes to unmapped or misaligned addresses (bits [1:0] not zero). Reads from unmapped or misaligned addresses return 0.
- R9: While a calculation runs, the quotient and remainder registers keep showing the previous result.
- R10: A divisor write during a calculation restarts it using the dividend register's current value. A dividend write during a calculation has no effect on the result being computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| addr | input | AW | Byte address of the access |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Combinational read data for `addr` |

## Verification
The assertions assume the following about the inputs:
- a divisor write lasts one cycle;
- the remainder bound is judged only when busy drops without a new start on that edge.

The stimulus keeps within this:
- it holds the write strobe for exactly one clock per access;
- between accesses it idles while rotating the read address across result and status words.

Restarts are issued only as clean single-cycle divisor writes at known points inside a run. This way the hold, restart and zero-divisor properties are all reached.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2
   } sdiv_state_e;

   // word indices of the register map (byte offset / 4)
   localparam int unsigned IDX_DVD = 0;
   localparam int unsigned IDX_DVS = 1;
   localparam int unsigned IDX_QUO = 2;
   localparam int unsigned IDX_REM = 3;
   localparam int unsigned IDX_STS = 4;

   // status word bit positions
   localparam int unsigned STS_DONE = 0;
   localparam int unsigned STS_ZERO = 1;

endpackage

// File: rtl/sdiv_core.sv
module sdiv_core
   import sdiv_pkg::*;
#(
   parameter int unsigned DW        = 32,
   parameter int unsigned SW        = 16,
   parameter bit          FIX_STAGE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [DW-1:0] dvd_i,
   input  logic [SW-1:0] dvs_i,
   output logic          busy_o,
   output logic [DW-1:0] quo_o,
   output logic [DW-1:0] rem_o
);

   localparam int unsigned CW = $clog2(DW);

   sdiv_state_e   state;
   logic [DW-1:0] q_work;
   logic [SW-1:0] r_work;
   logic [SW-1:0] d_mag;
   logic          neg_q;
   logic          neg_r;
   logic [CW-1:0] cnt;

   // operand conditioning
   logic          dvd_neg, dvs_neg, dvs_zero;
   logic [DW-1:0] dvd_mag;
   logic [SW-1:0] dvs_mag;
   logic [DW-1:0] zero_rem;

   always_comb begin
      dvd_neg  = dvd_i[DW-1];
      dvs_neg  = dvs_i[SW-1];
      dvs_zero = (dvs_i == '0);
      dvd_mag  = dvd_neg ? (DW'(0) - dvd_i) : dvd_i;
      dvs_mag  = dvs_neg ? (SW'(0) - dvs_i) : dvs_i;
      zero_rem = {{(DW-SW){dvd_i[SW-1]}}, dvd_i[SW-1:0]};
   end

   // one restoring step
   logic [SW:0]   r_sh;
   logic [SW-1:0] r_try;
   logic          take;
   logic [SW-1:0] r_nx;
   logic [DW-1:0] q_nx;

   always_comb begin
      r_sh  = {r_work, q_work[DW-1]};
      take  = (r_sh >= {1'b0, d_mag});
      r_try = r_sh[SW-1:0] - d_mag;
      r_nx  = take ? r_try : r_sh[SW-1:0];
      q_nx  = {q_work[DW-2:0], take};
   end

   // choose where sign correction happens
   logic [DW-1:0] fin_q;
   logic [SW-1:0] fin_r;
   logic          fin_now;

   generate
      if (FIX_STAGE) begin : g_fix_reg
         always_comb begin
            fin_q   = q_work;
            fin_r   = r_work;
            fin_now = (state == ST_FIX);
         end
      end else begin : g_fix_comb
         always_comb begin
            fin_q   = q_nx;
            fin_r   = r_nx;
            fin_now = (state == ST_RUN) && (cnt == '0);
         end
      end
   endgenerate

   logic [DW-1:0] quo_fix;
   logic [SW-1:0] rem_s;
   logic [DW-1:0] rem_fix;

   always_comb begin
      quo_fix = neg_q ? (DW'(0) - fin_q) : fin_q;
      rem_s   = neg_r ? (SW'(0) - fin_r) : fin_r;
      rem_fix = {{(DW-SW){rem_s[SW-1]}}, rem_s};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         q_work <= '0;
         r_work <= '0;
         d_mag  <= '0;
         neg_q  <= 1'b0;
         neg_r  <= 1'b0;
         cnt    <= '0;
         quo_o  <= '0;
         rem_o  <= '0;
      end else if (start_i) begin
         if (dvs_zero) begin
            state <= ST_IDLE;
            quo_o <= '1;
            rem_o <= zero_rem;
         end else begin
            state  <= ST_RUN;
            q_work <= dvd_mag;
            r_work <= '0;
            d_mag  <= dvs_mag;
            neg_q  <= dvd_neg ^ dvs_neg;
            neg_r  <= dvd_neg;
            cnt    <= CW'(DW-1);
         end
      end else begin
         case (state)
            ST_RUN: begin
               q_work <= q_nx;
               r_work <= r_nx;
               cnt    <= cnt - 1'b1;
               if (cnt == '0) state <= FIX_STAGE ? ST_FIX : ST_IDLE;
            end
            ST_FIX:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
         if (fin_now) begin
            quo_o <= quo_fix;
            rem_o <= rem_fix;
         end
      end
   end

   assign busy_o = (state != ST_IDLE);

   // checks
   logic [SW-1:0] rem_abs;
   assign rem_abs = rem_o[SW-1] ? (SW'(0) - rem_o[SW-1:0]) : rem_o[SW-1:0];

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && dvs_i != '0) |=> busy_o);

   // R6
   zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && dvs_i == '0) |=> (!busy_o && quo_o == '1));

   // R9
   hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i) |=> (!busy_o || ($stable(quo_o) && $stable(rem_o))));

   // R4
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && !$past(start_i)) |-> (rem_abs < d_mag));

   // R4
   rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy_o) && !$past(start_i) && rem_o != '0) |-> (rem_o[DW-1] == neg_r));

endmodule

// File: rtl/sdiv_regs.sv
module sdiv_regs
   import sdiv_pkg::*;
#(
   parameter int unsigned DW = 32,
   parameter int unsigned SW = 16,
   parameter int unsigned AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wr_data_i,
   output logic [DW-1:0] rd_data_o,
   input  logic [DW-1:0] quo_i,
   input  logic [DW-1:0] rem_i,
   input  logic          busy_i,
   output logic          start_o,
   output logic [DW-1:0] dvd_o,
   output logic [SW-1:0] dvs_o
);

   localparam int unsigned IW = AW - 2;

   logic [IW-1:0] idx;
   logic          aligned;
   logic          hit_dvd, hit_dvs, hit_quo, hit_rem, hit_sts;

   always_comb begin
      idx     = addr_i[AW-1:2];
      aligned = (addr_i[1:0] == 2'b00);
      hit_dvd = aligned && (idx == IW'(IDX_DVD));
      hit_dvs = aligned && (idx == IW'(IDX_DVS));
      hit_quo = aligned && (idx == IW'(IDX_QUO));
      hit_rem = aligned && (idx == IW'(IDX_REM));
      hit_sts = aligned && (idx == IW'(IDX_STS));
   end

   logic [DW-1:0] dvd_q;
   logic [SW-1:0] dvs_q;
   logic          zero_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dvd_q  <= '0;
         dvs_q  <= '0;
         zero_q <= 1'b0;
      end else if (wr_en_i) begin
         if (hit_dvd) dvd_q <= wr_data_i;
         if (hit_dvs) begin
            dvs_q  <= wr_data_i[SW-1:0];
            zero_q <= (wr_data_i[SW-1:0] == '0);
         end
      end
   end

   assign start_o = wr_en_i && hit_dvs;
   assign dvd_o   = dvd_q;
   assign dvs_o   = wr_data_i[SW-1:0];

   logic [DW-1:0] sts_word;
   always_comb begin
      sts_word           = '0;
      sts_word[STS_DONE] = ~busy_i;
      sts_word[STS_ZERO] = zero_q;
   end

   always_comb begin
      rd_data_o = '0;
      if (hit_dvd) rd_data_o = dvd_q;
      if (hit_dvs) rd_data_o = {{(DW-SW){1'b0}}, dvs_q};
      if (hit_quo) rd_data_o = quo_i;
      if (hit_rem) rd_data_o = rem_i;
      if (hit_sts) rd_data_o = sts_word;
   end

   // R5
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> (zero_q == ($past(wr_data_i[SW-1:0]) == '0)));

   // R1
   dvs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> (dvs_q == $past(wr_data_i[SW-1:0])));

   // R8
   dvd_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en_i && hit_dvd) |=> $stable(dvd_q));

endmodule

// File: rtl/sdiv_unit.sv
module sdiv_unit #(
   parameter int unsigned DW        = 32,
   parameter int unsigned SW        = 16,
   parameter int unsigned AW        = 5,
   parameter bit          FIX_STAGE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wr_data,
   output logic [DW-1:0] rd_data
);

   initial begin
      param_sw_chk: assert (SW >= 2 && SW < DW)
         else $error("divisor width must be in [2, DW-1]");
      param_aw_chk: assert (AW >= 5)
         else $error("address width too small for five words");
   end

   logic          start;
   logic          busy;
   logic [DW-1:0] dvd;
   logic [SW-1:0] dvs;
   logic [DW-1:0] quo;
   logic [DW-1:0] rem;

   sdiv_regs #(
      .DW(DW), .SW(SW), .AW(AW)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en),
      .addr_i    (addr),
      .wr_data_i (wr_data),
      .rd_data_o (rd_data),
      .quo_i     (quo),
      .rem_i     (rem),
      .busy_i    (busy),
      .start_o   (start),
      .dvd_o     (dvd),
      .dvs_o     (dvs)
   );

   sdiv_core #(
      .DW(DW), .SW(SW), .FIX_STAGE(FIX_STAGE)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .dvd_i   (dvd),
      .dvs_i   (dvs),
      .busy_o  (busy),
      .quo_o   (quo),
      .rem_o   (rem)
   );

endmodule

// File: tb/sdiv_unit_tb.sv
module sdiv_unit_tb;

   localparam int DW  = 32;
   localparam int SW  = 16;
   localparam int AW  = 5;
   localparam bit FIX = 1'b1;
   localparam int LAT = DW + FIX;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wr_data = '0;
   logic [31:0]   rd_data;

   always #10 clk = ~clk;

   sdiv_unit #(.DW(DW), .SW(SW), .AW(AW), .FIX_STAGE(FIX)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data)
   );

   int errs = 0;
   int checks = 0;
   int cyc = 0;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errs++;
         $display("FAIL %s got=%h exp=%h (t=%0t)", tag, got, exp, $time);
      end
   endtask

   function automatic logic [31:0] ref_q(input logic [31:0] a, input logic [15:0] b);
      longint x, y;
      if (b == 16'h0) return 32'hFFFF_FFFF;
      x = longint'($signed(a));
      y = longint'($signed(b));
      return 32'(x / y);
   endfunction

   function automatic logic [31:0] ref_r(input logic [31:0] a, input logic [15:0] b);
      longint x, y;
      if (b == 16'h0) return {{16{a[15]}}, a[15:0]};
      x = longint'($signed(a));
      y = longint'($signed(b));
      return 32'(x % y);
   endfunction

   // behavioural reference model
   logic [31:0] m_dvd, m_quo, m_rem, p_quo, p_rem;
   logic [15:0] m_dvs;
   logic        m_zero;
   int          m_left;
   logic        m_dvs_wr;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_dvd = 0; m_dvs = 0; m_zero = 0; m_quo = 0; m_rem = 0;
         p_quo = 0; p_rem = 0; m_left = 0;
      end else begin
         m_dvs_wr = wr_en && addr[1:0] == 2'b00 && addr[4:2] == 3'd1;
         if (!m_dvs_wr && m_left > 0) begin
            m_left--;
            if (m_left == 0) begin
               m_quo = p_quo;
               m_rem = p_rem;
            end
         end
         if (wr_en && addr[1:0] == 2'b00) begin
            if (addr[4:2] == 3'd0) m_dvd = wr_data;
            if (addr[4:2] == 3'd1) begin
               m_dvs  = wr_data[15:0];
               m_zero = (m_dvs == 16'h0);
               if (m_zero) begin
                  m_quo  = ref_q(m_dvd, m_dvs);
                  m_rem  = ref_r(m_dvd, m_dvs);
                  m_left = 0;
               end else begin
                  p_quo  = ref_q(m_dvd, m_dvs);
                  p_rem  = ref_r(m_dvd, m_dvs);
                  m_left = LAT;
               end
            end
         end
      end
   end

   function automatic logic [31:0] model_rd(input logic [AW-1:0] a);
      if (a[1:0] != 2'b00) return 32'h0;
      case (a[4:2])
         3'd0:    return m_dvd;
         3'd1:    return {16'h0, m_dvs};
         3'd2:    return m_quo;
         3'd3:    return m_rem;
         3'd4:    return {30'h0, m_zero, (m_left == 0)};
         default: return 32'h0;
      endcase
   endfunction

   // per-cycle comparison against the model
   always begin
      string tag;
      @(posedge clk);
      #5;
      if (rst_n) begin
         if (addr[1:0] != 2'b00) tag = "R8";
         else begin
            case (addr[4:2])
               3'd0, 3'd1: tag = "R1";
               3'd2:       tag = (m_left > 0) ? "R9" : "R3";
               3'd3:       tag = (m_left > 0) ? "R9" : "R4";
               3'd4:       tag = "R2";
               default:    tag = "R8";
            endcase
         end
         chk(tag, rd_data, model_rd(addr));
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errs++;
         $display("FAIL R2 watchdog cycles=%0d exp<=150000", cyc);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   int rot = 0;

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = $urandom;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         case (rot % 5)
            0: addr = 5'h08;
            1: addr = 5'h0C;
            2: addr = 5'h10;
            3: addr = 5'h00;
            default: addr = 5'h04;
         endcase
         rot++;
      end
   endtask

   task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
      @(negedge clk);
      addr = a;
      #5;
      chk(tag, rd_data, exp);
   endtask

   task automatic div_chk(input logic [31:0] a, input logic [15:0] b);
      wr(5'h00, a);
      wr(5'h04, {16'h0, b});
      idle(LAT + 2);
      if (b == 16'h0) begin
         rd_chk("R6", 5'h08, 32'hFFFF_FFFF);
         rd_chk("R6", 5'h0C, {{16{a[15]}}, a[15:0]});
      end else begin
         rd_chk("R3", 5'h08, ref_q(a, b));
         rd_chk("R4", 5'h0C, ref_r(a, b));
      end
      rd_chk("R5", 5'h10, {30'h0, (b == 16'h0), 1'b1});
   endtask

   initial begin
      int n;
      // R7 reset state
      repeat (3) @(negedge clk);
      rd_chk("R7", 5'h10, 32'h1);
      rd_chk("R7", 5'h08, 32'h0);
      rd_chk("R7", 5'h0C, 32'h0);
      rd_chk("R7", 5'h00, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      rd_chk("R7", 5'h04, 32'h0);

      // R2 latency of the done flag
      wr(5'h00, 32'd1000);
      wr(5'h04, 32'd7);
      addr = 5'h10;
      #1;
      n = 0;
      while (rd_data[0] == 1'b0 && n < 100) begin
         n++;
         @(negedge clk);
         #1;
      end
      chk("R2", 32'(n), 32'(LAT));
      rd_chk("R3", 5'h08, 32'd142);

      // R3 / R4 sign combinations and edges
      div_chk(32'd100, 16'd7);
      div_chk(-32'sd100, 16'd7);
      div_chk(32'd100, -16'sd7);
      div_chk(-32'sd100, -16'sd7);
      div_chk(32'h8000_0000, 16'hFFFF);
      div_chk(32'h8000_0000, 16'h0001);
      div_chk(32'h7FFF_FFFF, 16'h8000);
      div_chk(32'hFFFF_FFFF, 16'h8000);
      div_chk(32'd5, 16'h8000);
      div_chk(32'd0, 16'd3);
      // R6 zero divisor
      div_chk(32'h1234_8765, 16'h0);
      div_chk(32'h0000_7FFF, 16'h0);
      wr(5'h00, 32'hABCD_8001);
      wr(5'h04, 32'h0);
      rd_chk("R6", 5'h10, 32'h3);
      rd_chk("R6", 5'h0C, 32'hFFFF_8001);

      // R1 divisor upper bits dropped
      wr(5'h04, 32'hABCD_0005);
      rd_chk("R1", 5'h04, 32'h0000_0005);
      rd_chk("R5", 5'h10, 32'h0);
      idle(LAT + 2);

      // R10 restart with the current dividend
      wr(5'h00, 32'd1000);
      wr(5'h04, 32'd3);
      idle(10);
      wr(5'h00, -32'sd7000);
      idle(5);
      wr(5'h04, 32'd9);
      idle(LAT + 2);
      rd_chk("R10", 5'h08, -32'sd777);
      rd_chk("R10", 5'h0C, -32'sd7);
      // R10 dividend write alone does not disturb the run
      wr(5'h00, 32'd500);
      wr(5'h04, 32'd10);
      idle(5);
      wr(5'h00, 32'd99);
      rd_chk("R9", 5'h08, -32'sd777);
      idle(LAT);
      rd_chk("R10", 5'h08, 32'd50);
      rd_chk("R1", 5'h00, 32'd99);

      // R8 ignored writes and unmapped reads
      wr(5'h08, 32'h1111_1111);
      wr(5'h0C, 32'h2222_2222);
      wr(5'h10, 32'h0);
      wr(5'h05, 32'h0);
      wr(5'h18, 32'h3333_3333);
      rd_chk("R8", 5'h08, 32'd50);
      rd_chk("R8", 5'h0C, 32'd0);
      rd_chk("R8", 5'h10, 32'h1);
      rd_chk("R8", 5'h04, 32'd10);
      rd_chk("R8", 5'h18, 32'h0);
      rd_chk("R8", 5'h09, 32'h0);

      // random operations, some zero divisors and restarts
      for (int i = 0; i < 300; i++) begin
         logic [31:0] a;
         logic [15:0] b;
         a = $urandom;
         b = ($urandom % 16 == 0) ? 16'h0 : 16'($urandom);
         if (i % 3 == 0) b = 16'($signed(b) >>> ($urandom % 14));
         if (i % 7 == 0) begin
            wr(5'h00, $urandom);
            wr(5'h04, 32'($urandom % 200 + 1));
            idle($urandom % 20);
         end
         div_chk(a, b);
      end

      idle(3);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule